// File: doc/BRIEF.md
# Transaction-Counting Phase Barrier

This block is one reusable completion barrier for asynchronous producer and consumer agents. It tracks two counts that must both reach zero before a round ends. The first counts the arrivals still missing. The second counts the transaction bytes that are still outstanding. A one-bit phase toggles each time a round finishes. Software-side threads arrive on the barrier. An arrival can also announce a byte budget that a copy agent later pays off in delivered chunks. A consumer asks whether a round is over by presenting the parity it expects.

The arrival count written at set-up is kept. When a round completes, the count is reloaded, so the same barrier can serve an unbounded series of rounds without being set up again. Events that land together in one cycle are merged before completion is evaluated. Bytes delivered before their budget is announced are carried as a negative balance. A sticky flag records misuse.

Top module: `txn_phase_barrier`

## Requirements
- R1: After reset `phase_o` is 0, `err_o` is 0 and `done_o` is 0 while `wait_vld_i` is low.
- R2: `init_i` loads `init_cnt_i` as the arrival count and as the stored reload value. It clears the pending bytes, sets the phase to 0 and clears `err_o`. All other events in that cycle are ignored.
- R3: `arrive_i` lowers the arrival count by one and leaves the pending bytes unchanged.
- R4: `arrive_tx_i` adds `tx_bytes_i` to the pending bytes and also lowers the arrival count by one.
- R5: `cmpl_i` subtracts `cmpl_bytes_i` from the pending bytes. In a round set up with one arrival and a 32768-byte budget, four 8192-byte deliveries flip the phase only after the fourth.
- R6: In a cycle that carries at least one of `arrive_i`, `arrive_tx_i` or `cmpl_i`, the phase toggles at that clock edge when the arrival count and the pending bytes are both zero after all of the cycle's events are applied. A cycle with none of these events never changes the phase.
- R7: `done_o` is combinational and equals `wait_vld_i` AND (`phase_o` != `wait_par_i`). A query with a stale parity therefore reports done at once.
- R8: When a round completes, the arrival count reloads from the stored value, so the next round needs no new `init_i`.
- R9: A delivery that comes before its budget is announced leaves the pending bytes negative. The round then completes only when the announced budget brings the balance back to zero.
- R10: An arrival that would take the arrival count below zero sets `err_o` and leaves the count at zero. `err_o` stays set until `init_i` or reset.
- R11: A query with `wait_vld_i` high in the same cycle that a round completes sets `err_o`.
- R12: `arrive_i` and `arrive_tx_i` in the same cycle count as two arrivals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| init_i | input | 1 | set-up strobe |
| init_cnt_i | input | CNT_W | arrivals expected per round |
| arrive_i | input | 1 | plain arrival |
| arrive_tx_i | input | 1 | arrival that announces a byte budget |
| tx_bytes_i | input | TX_W | announced byte budget |
| cmpl_i | input | 1 | byte delivery from the copy agent |
| cmpl_bytes_i | input | TX_W | bytes delivered |
| wait_vld_i | input | 1 | parity query valid |
| wait_par_i | input | 1 | parity the query expects |
| done_o | output | 1 | query result: round with that parity is over |
| phase_o | output | 1 | current phase |
| err_o | output | 1 | sticky misuse flag |

## Verification
`done_o` is due in the same cycle as its query, because it is combinational from the registered phase. The bench checks it 1 ns after it drives the inputs, which happens just after the falling edge. `phase_o` and `err_o` are due one edge after the cycle that carries the event. The bench checks them 1 ns after that rising edge against a reference model that it updates at the same edge. Directed rounds cover the chunked byte delivery, events in the same cycle, early deliveries, underflow and a query racing a flip. A seeded random run mixes all event kinds and re-initializes the barrier periodically.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int unsigned CNT_W_DEF = 20;
  localparam int unsigned TX_W_DEF  = 17;
  localparam int unsigned PEND_PAD  = 4;
  // arrivals presented in one cycle: plain + budget-carrying
  typedef logic [1:0] arr_dec_t;
endpackage

// File: rtl/txb_arrive_ctr.sv
module txb_arrive_ctr
  import txb_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [CNT_W-1:0] init_cnt_i,
  input  arr_dec_t         dec_i,
  input  logic             flip_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             uflow_o
);
  logic [CNT_W-1:0] cnt_q, reload_q, dec_w;

  assign dec_w     = CNT_W'(dec_i);
  assign uflow_o   = dec_w > cnt_q;
  assign cnt_nxt_o = uflow_o ? '0 : cnt_q - dec_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (init_i) begin
      cnt_q    <= init_cnt_i;
      reload_q <= init_cnt_i;
    end else if (flip_i) begin
      cnt_q    <= reload_q;
    end else begin
      cnt_q    <= cnt_nxt_o;
    end
  end
endmodule

// File: rtl/txb_byte_ctr.sv
module txb_byte_ctr
  import txb_pkg::*;
#(
  parameter int unsigned TX_W = TX_W_DEF,
  localparam int unsigned PEND_W = TX_W + PEND_PAD
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     init_i,
  input  logic                     add_i,
  input  logic [TX_W-1:0]          add_bytes_i,
  input  logic                     sub_i,
  input  logic [TX_W-1:0]          sub_bytes_i,
  input  logic                     flip_i,
  output logic signed [PEND_W-1:0] pend_nxt_o
);
  logic signed [PEND_W-1:0] pend_q, add_w, sub_w;

  // negative balance = bytes delivered ahead of their budget
  assign add_w      = add_i ? $signed({{PEND_PAD{1'b0}}, add_bytes_i}) : '0;
  assign sub_w      = sub_i ? $signed({{PEND_PAD{1'b0}}, sub_bytes_i}) : '0;
  assign pend_nxt_o = pend_q + add_w - sub_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pend_q <= '0;
    else if (init_i || flip_i)  pend_q <= '0;
    else                        pend_q <= pend_nxt_o;
  end
endmodule

// File: rtl/txn_phase_barrier.sv
module txn_phase_barrier
  import txb_pkg::*;
#(
  parameter int unsigned CNT_W = CNT_W_DEF,
  parameter int unsigned TX_W  = TX_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic [CNT_W-1:0] init_cnt_i,
  input  logic             arrive_i,
  input  logic             arrive_tx_i,
  input  logic [TX_W-1:0]  tx_bytes_i,
  input  logic             cmpl_i,
  input  logic [TX_W-1:0]  cmpl_bytes_i,
  input  logic             wait_vld_i,
  input  logic             wait_par_i,
  output logic             done_o,
  output logic             phase_o,
  output logic             err_o
);
  localparam int unsigned PEND_W = TX_W + PEND_PAD;

  logic [CNT_W-1:0]         cnt_nxt;
  logic signed [PEND_W-1:0] pend_nxt;
  logic                     uflow, ev, flip, phase_q, err_q;
  arr_dec_t                 dec;

  assign dec  = arr_dec_t'(arrive_i) + arr_dec_t'(arrive_tx_i);
  assign ev   = arrive_i | arrive_tx_i | cmpl_i;
  assign flip = !init_i && ev && (cnt_nxt == '0) && (pend_nxt == '0);

  txb_arrive_ctr #(.CNT_W(CNT_W)) i_arrive_ctr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_i),
    .init_cnt_i (init_cnt_i),
    .dec_i      (dec),
    .flip_i     (flip),
    .cnt_nxt_o  (cnt_nxt),
    .uflow_o    (uflow)
  );

  txb_byte_ctr #(.TX_W(TX_W)) i_byte_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_i      (init_i),
    .add_i       (arrive_tx_i),
    .add_bytes_i (tx_bytes_i),
    .sub_i       (cmpl_i),
    .sub_bytes_i (cmpl_bytes_i),
    .flip_i      (flip),
    .pend_nxt_o  (pend_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (init_i) begin
      phase_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (flip) phase_q <= ~phase_q;
      if (uflow || (flip && wait_vld_i)) err_q <= 1'b1;
    end
  end

  assign done_o  = wait_vld_i && (phase_q != wait_par_i);
  assign phase_o = phase_q;
  assign err_o   = err_q;
endmodule

// File: rtl/txb_checker.sv
module txb_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic init_i,
  input logic arrive_i,
  input logic arrive_tx_i,
  input logic cmpl_i,
  input logic wait_vld_i,
  input logic wait_par_i,
  input logic done_o,
  input logic phase_o,
  input logic err_o
);
  AST_INIT_PHASE0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> (!phase_o && !err_o)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!init_i && !arrive_i && !arrive_tx_i && !cmpl_i) |=> $stable(phase_o)); // R6
  AST_STALE_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_vld_i && !$stable(phase_o) && (wait_par_i == $past(phase_o))) |-> done_o); // R7
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !init_i) |=> err_o); // R10
  AST_CMPL_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_o && cmpl_i && !arrive_i && !arrive_tx_i && !wait_vld_i && !init_i) |=> !err_o); // R5
endmodule

bind txn_phase_barrier txb_checker i_txb_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .init_i      (init_i),
  .arrive_i    (arrive_i),
  .arrive_tx_i (arrive_tx_i),
  .cmpl_i      (cmpl_i),
  .wait_vld_i  (wait_vld_i),
  .wait_par_i  (wait_par_i),
  .done_o      (done_o),
  .phase_o     (phase_o),
  .err_o       (err_o)
);

// File: tb/test_txn_phase_barrier.sv
module test_txn_phase_barrier;
  localparam int unsigned CNT_W = 20;
  localparam int unsigned TX_W  = 17;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic init_i = 0, arrive_i = 0, arrive_tx_i = 0, cmpl_i = 0, wait_vld_i = 0, wait_par_i = 0;
  logic [CNT_W-1:0] init_cnt_i = '0;
  logic [TX_W-1:0]  tx_bytes_i = '0, cmpl_bytes_i = '0;
  logic done_o, phase_o, err_o;

  int total = 0, bad = 0;
  int m_arr = 0, m_reload = 0, m_pend = 0;
  bit m_phase = 0, m_err = 0, finished = 0;

  always #2 clk_i = ~clk_i;

  txn_phase_barrier #(.CNT_W(CNT_W), .TX_W(TX_W)) i_txn_phase_barrier (.*);

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic bit exp_done(input bit wv, input bit wp);
    return wv && (m_phase != wp);
  endfunction

  task automatic model(input bit ini, input int icnt, input bit a, input bit at, input int tb,
                       input bit c, input int cb, input bit wv);
    int dec;
    if (ini) begin
      m_arr = icnt; m_reload = icnt; m_pend = 0; m_phase = 0; m_err = 0;
      return;
    end
    dec = int'(a) + int'(at);
    if (dec > m_arr) begin m_err = 1; m_arr = 0; end
    else m_arr -= dec;
    if (at) m_pend += tb;
    if (c)  m_pend -= cb;
    if ((a || at || c) && m_arr == 0 && m_pend == 0) begin
      m_phase = ~m_phase; m_arr = m_reload;
      if (wv) m_err = 1;
    end
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic op(input string tag, input bit ini, input int icnt, input bit a, input bit at,
                    input int tb, input bit c, input int cb, input bit wv, input bit wp);
    init_i = ini; init_cnt_i = CNT_W'(icnt); arrive_i = a; arrive_tx_i = at;
    tx_bytes_i = TX_W'(tb); cmpl_i = c; cmpl_bytes_i = TX_W'(cb);
    wait_vld_i = wv; wait_par_i = wp;
    #1;
    chk(tag, "done_o", int'(done_o), int'(exp_done(wv, wp)));
    @(posedge clk_i);
    model(ini, icnt, a, at, tb, c, cb, wv);
    #1;
    chk(tag, "phase_o", int'(phase_o), int'(m_phase));
    chk(tag, "err_o", int'(err_o), int'(m_err));
    @(negedge clk_i);
    init_i = 0; arrive_i = 0; arrive_tx_i = 0; cmpl_i = 0; wait_vld_i = 0;
  endtask

  task automatic idle(input string tag);
    op(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    @(negedge clk_i); @(negedge clk_i);
    // R1 reset state
    #1;
    chk("R1", "phase_o", int'(phase_o), 0);
    chk("R1", "err_o", int'(err_o), 0);
    chk("R1", "done_o", int'(done_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 / R4 / R5: one arrival, 32768-byte budget, four 8192-byte chunks
    op("R2", 1, 1, 0, 0, 0, 0, 0, 0, 0);
    op("R4", 0, 0, 0, 1, 32768, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) op("R5", 0, 0, 0, 0, 0, 1, 8192, 0, 0);
    chk("R5", "phase before last chunk", int'(phase_o), 0);
    op("R5", 0, 0, 0, 0, 0, 1, 8192, 0, 0);
    chk("R5", "phase after last chunk", int'(phase_o), 1);
    // R7 stale parity done, current parity not done
    op("R7", 0, 0, 0, 0, 0, 0, 0, 1, 0);
    op("R7", 0, 0, 0, 0, 0, 0, 0, 1, 1);
    // R8 reload without init; R3 plain arrive completes
    op("R3", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R8", "phase after reloaded round", int'(phase_o), 0);
    // R6 idle cycles never flip
    op("R2", 1, 0, 0, 0, 0, 0, 0, 0, 0);
    idle("R6"); idle("R6");
    chk("R6", "phase idle", int'(phase_o), 0);
    // R12 two arrivals in one cycle
    op("R2", 1, 2, 0, 0, 0, 0, 0, 0, 0);
    op("R12", 0, 0, 1, 1, 0, 0, 0, 0, 0);
    chk("R12", "phase after double arrival", int'(phase_o), 1);
    // R6 budget and delivery in the same cycle
    op("R2", 1, 1, 0, 0, 0, 0, 0, 0, 0);
    op("R6", 0, 0, 0, 1, 100, 1, 100, 0, 0);
    chk("R6", "same-cycle flip", int'(phase_o), 1);
    // R9 early delivery held negative
    op("R2", 1, 1, 0, 0, 0, 0, 0, 0, 0);
    op("R9", 0, 0, 0, 0, 0, 1, 500, 0, 0);
    op("R9", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R9", "no flip while negative", int'(phase_o), 0);
    op("R9", 0, 0, 0, 0, 0, 1, 0, 0, 0);
    op("R2", 1, 2, 0, 0, 0, 0, 0, 0, 0);
    op("R9", 0, 0, 0, 0, 0, 1, 500, 0, 0);
    op("R9", 0, 0, 0, 1, 500, 0, 0, 0, 0);
    op("R9", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R9", "flip once budget met", int'(phase_o), 1);
    // R10 underflow, sticky, cleared by init
    op("R2", 1, 1, 0, 0, 0, 0, 0, 0, 0);
    op("R10", 0, 0, 0, 1, 64, 0, 0, 0, 0);
    op("R10", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    chk("R10", "err after underflow", int'(err_o), 1);
    idle("R10"); idle("R10");
    chk("R10", "err sticky", int'(err_o), 1);
    op("R2", 1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R2", "err cleared by init", int'(err_o), 0);
    // R2 init ignores other events
    op("R2", 1, 1, 1, 1, 8, 1, 8, 0, 0);
    chk("R2", "phase after init with events", int'(phase_o), 0);
    // R11 query racing a flip
    op("R11", 0, 0, 1, 0, 0, 0, 0, 1, 0);
    chk("R11", "err on racing query", int'(err_o), 1);

    // random mix against the model
    for (int n = 0; n < 3000; n++) begin
      bit ini, a, at, c, wv, wp;
      int icnt, tb, cb;
      ini = (n % 40 == 0) || ($urandom_range(0, 49) == 0);
      icnt = $urandom_range(0, 3);
      a = $urandom_range(0, 3) == 0;
      at = $urandom_range(0, 4) == 0;
      c = $urandom_range(0, 2) == 0;
      tb = 256 * $urandom_range(0, 8);
      cb = 256 * $urandom_range(0, 4);
      wv = $urandom_range(0, 5) == 0;
      wp = 1'($urandom_range(0, 1));
      op("R6", ini, icnt, a, at, tb, c, cb, wv, wp);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule